// File: doc/BRIEF.md
# Interrupt Summary and Mask Unit

This unit collects nineteen level-sensitive interrupt request lines from expansion slots and on-board functions and presents them to software as three consecutive byte-wide registers on an 8-bit synchronous I/O bus. Each line has its own mask bit. Software writes the mask through the same three addresses it reads. A read never returns the mask: it returns the raw, unmasked level of the request lines. Software therefore keeps its own copy of the mask.

The unit drives one combined, registered interrupt line toward the processor. This line is high whenever at least one unmasked request is active. A second registered output names the lowest-numbered pending unmasked line, so a handler can start service without scanning the bytes. Line 4 carries the cascaded legacy interrupt controller output and is treated like every other line. No request is latched. A line stops being pending as soon as its input drops, and there is nothing to acknowledge.

Each bus cycle is decoded into one of three access kinds: none, read, or write. If both strobes are high in the same cycle, the cycle counts as a write. A read loads the read-data register at the clock edge, and that register holds its value until the next read. A write updates one mask byte at the edge.

Top module: `pci_irq_summary`

## Requirements
- R1: After reset, every mask bit is 1 (all lines disabled), `cpu_irq` and `pend_valid` are 0, `pend_idx` is 0, and `bus_rdata` is 0x00. Raising requests before any mask write produces no interrupt.
- R2: A write at address BASE+k (k = 0, 1, 2) loads the write data into mask byte k at the clock edge. A 1 in a bit disables that line, and a 0 enables it.
- R3: A read at BASE+k loads `bus_rdata` at the clock edge with the raw levels of request byte k, whatever the mask holds.
- R4: Line n sits at byte n/8, bit n%8, so lines 0..7 are at BASE, lines 8..15 at BASE+1, and lines 16..18 in bits 0..2 of BASE+2. Bits 7..3 of BASE+2 always read as 0, and writing them has no effect.
- R5: `cpu_irq` is registered. It equals, one clock after the fact, the OR over all lines of (request AND NOT mask), using the mask as it was before any write in that same cycle.
- R6: `pend_valid` equals `cpu_irq`. When it is high, `pend_idx` (5 bits) holds the lowest line number that is both requested and unmasked. When it is low, `pend_idx` is 0. Both outputs follow the same one-clock timing as `cpu_irq`.
- R7: A read at any address outside BASE..BASE+2 returns 0xFF. A write outside that range changes no mask bit.
- R8: `bus_rdata` keeps its value in every cycle that has no read.
- R9: Requests are level-sensitive. When an unmasked request drops, `cpu_irq` falls one clock later, unless another unmasked line is still active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 12 | I/O address |
| bus_wr | input | 1 | Write strobe, one cycle |
| bus_rd | input | 1 | Read strobe, one cycle |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| irq_req | input | 19 | Level-sensitive request lines |
| cpu_irq | output | 1 | Combined unmasked interrupt toward the processor |
| pend_idx | output | 5 | Lowest pending unmasked line |
| pend_valid | output | 1 | Some unmasked line is pending |

## Verification
The bench first raises every request while all lines are still masked from reset. This shows that reset really disables the lines, rather than the interrupt path being dead. Single-line patterns, including the cascade line 4 and the top line 18, are then walked through each mask byte. These patterns separate a wrong byte or bit position from a wrong priority order. Several lines are raised together to show that the index picks the lowest unmasked line and skips lower lines that are masked. Reads made under a fully set mask and a fully clear mask show that the read path returns raw levels, not masked ones. A long stretch of random requests, masks and addresses, including addresses just outside the range, is compared every cycle against the behavioural model.

// File: rtl/pci_irq_pkg.sv
package pci_irq_pkg;
    typedef enum logic [1:0] {
        ACC_NONE  = 2'd0,
        ACC_READ  = 2'd1,
        ACC_WRITE = 2'd2
    } acc_kind_t;
endpackage

// File: rtl/pis_mask_bank.sv
module pis_mask_bank #(
    parameter int LINES  = 19,
    parameter int BYTE_W = 8,
    parameter int SEL_W  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [SEL_W-1:0]  sel,
    input  logic [BYTE_W-1:0] wdata,
    output logic [LINES-1:0]  mask
);
    for (genvar i = 0; i < LINES; i++) begin : g_bit
        localparam int BYTE_IDX = i / BYTE_W;
        localparam int BIT_IDX  = i % BYTE_W;
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                mask[i] <= 1'b1;
            end else if (wr_en && (sel == SEL_W'(BYTE_IDX))) begin
                mask[i] <= wdata[BIT_IDX];
            end
        end
    end
endmodule

// File: rtl/pis_lowest.sv
module pis_lowest #(
    parameter int LINES = 19,
    parameter int IDX_W = 5
) (
    input  logic [LINES-1:0] pend,
    output logic [IDX_W-1:0] idx,
    output logic             valid
);
    always_comb begin
        idx   = '0;
        valid = |pend;
        for (int i = LINES - 1; i >= 0; i--) begin
            if (pend[i]) begin
                idx = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/pis_read_port.sv
module pis_read_port #(
    parameter int LINES    = 19,
    parameter int BYTE_W   = 8,
    parameter int NUM_REGS = 3,
    parameter int SEL_W    = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_en,
    input  logic              hit,
    input  logic [SEL_W-1:0]  sel,
    input  logic [LINES-1:0]  req,
    output logic [BYTE_W-1:0] rdata
);
    localparam int TOTAL = NUM_REGS * BYTE_W;

    logic [TOTAL-1:0]  padded;
    logic [BYTE_W-1:0] picked;

    assign padded = {{(TOTAL - LINES){1'b0}}, req};
    assign picked = hit ? padded[int'(sel) * BYTE_W +: BYTE_W] : {BYTE_W{1'b1}};

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata <= '0;
        end else if (rd_en) begin
            rdata <= picked;
        end
    end
endmodule

// File: rtl/pci_irq_summary.sv
module pci_irq_summary #(
    parameter int              LINES     = 19,
    parameter int              BYTE_W    = 8,
    parameter int              ADDR_W    = 12,
    parameter logic [ADDR_W-1:0] BASE_ADDR = 12'h804
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [ADDR_W-1:0]        bus_addr,
    input  logic                     bus_wr,
    input  logic                     bus_rd,
    input  logic [BYTE_W-1:0]        bus_wdata,
    output logic [BYTE_W-1:0]        bus_rdata,
    input  logic [LINES-1:0]         irq_req,
    output logic                     cpu_irq,
    output logic [$clog2(LINES)-1:0] pend_idx,
    output logic                     pend_valid
);
    import pci_irq_pkg::*;

    localparam int NUM_REGS = (LINES + BYTE_W - 1) / BYTE_W;
    localparam int SEL_W    = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;
    localparam int IDX_W    = $clog2(LINES);

    logic [ADDR_W-1:0] offset;
    logic              hit;
    logic [SEL_W-1:0]  sel;
    acc_kind_t         acc;
    logic              wr_en;
    logic              rd_en;
    logic [LINES-1:0]  mask_q;
    logic [LINES-1:0]  pend;
    logic [IDX_W-1:0]  low_idx;
    logic              low_valid;

    assign offset = bus_addr - BASE_ADDR;
    assign hit    = (bus_addr >= BASE_ADDR) && (offset < ADDR_W'(NUM_REGS));
    assign sel    = offset[SEL_W-1:0];

    always_comb begin
        if (bus_wr)      acc = ACC_WRITE;
        else if (bus_rd) acc = ACC_READ;
        else             acc = ACC_NONE;
    end

    always_comb begin
        wr_en = 1'b0;
        rd_en = 1'b0;
        unique case (acc)
            ACC_NONE:  ;
            ACC_READ:  rd_en = 1'b1;
            ACC_WRITE: wr_en = hit;
            default:   ;
        endcase
    end

    pis_mask_bank #(.LINES(LINES), .BYTE_W(BYTE_W), .SEL_W(SEL_W)) u_mask (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (wr_en),
        .sel   (sel),
        .wdata (bus_wdata),
        .mask  (mask_q)
    );

    pis_read_port #(.LINES(LINES), .BYTE_W(BYTE_W), .NUM_REGS(NUM_REGS), .SEL_W(SEL_W)) u_rd (
        .clk   (clk),
        .rst_n (rst_n),
        .rd_en (rd_en),
        .hit   (hit),
        .sel   (sel),
        .req   (irq_req),
        .rdata (bus_rdata)
    );

    assign pend = irq_req & ~mask_q;

    pis_lowest #(.LINES(LINES), .IDX_W(IDX_W)) u_low (
        .pend  (pend),
        .idx   (low_idx),
        .valid (low_valid)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cpu_irq    <= 1'b0;
            pend_valid <= 1'b0;
            pend_idx   <= '0;
        end else begin
            cpu_irq    <= |pend;
            pend_valid <= low_valid;
            pend_idx   <= low_idx;
        end
    end
endmodule

// File: rtl/pis_checker.sv
module pis_checker #(
    parameter int                LINES     = 19,
    parameter int                BYTE_W    = 8,
    parameter int                ADDR_W    = 12,
    parameter logic [ADDR_W-1:0] BASE_ADDR = 12'h804
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic [ADDR_W-1:0]        bus_addr,
    input logic                     bus_wr,
    input logic                     bus_rd,
    input logic [BYTE_W-1:0]        bus_wdata,
    input logic [BYTE_W-1:0]        bus_rdata,
    input logic [LINES-1:0]         irq_req,
    input logic [LINES-1:0]         mask,
    input logic                     cpu_irq,
    input logic [$clog2(LINES)-1:0] pend_idx,
    input logic                     pend_valid
);
    logic in_rng;
    logic rd_only;
    assign in_rng  = (bus_addr == BASE_ADDR) || (bus_addr == BASE_ADDR + 1) ||
                     (bus_addr == BASE_ADDR + 2);
    assign rd_only = bus_rd && !bus_wr;

    p_reset_masked_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (&mask));

    p_mask_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == BASE_ADDR) |=> (mask[BYTE_W-1:0] == $past(bus_wdata)));

    p_read_raw_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_only && bus_addr == BASE_ADDR) |=> (bus_rdata == $past(irq_req[BYTE_W-1:0])));

    p_reserved_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_only && bus_addr == BASE_ADDR + 2) |=> (bus_rdata[BYTE_W-1:3] == '0));

    p_irq_on_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (|(irq_req & ~mask)) |=> cpu_irq);

    p_irq_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(|(irq_req & ~mask)) |=> !cpu_irq);

    p_valid_match_r6: assert property (@(posedge clk) disable iff (!rst_n)
        pend_valid == cpu_irq);

    p_idx_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
        pend_valid |-> (int'(pend_idx) < LINES));

    p_out_of_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_only && !in_rng) |=> (bus_rdata == {BYTE_W{1'b1}}));

    p_rdata_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |=> $stable(bus_rdata));
endmodule

bind pci_irq_summary pis_checker #(
    .LINES(LINES), .BYTE_W(BYTE_W), .ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_addr   (bus_addr),
    .bus_wr     (bus_wr),
    .bus_rd     (bus_rd),
    .bus_wdata  (bus_wdata),
    .bus_rdata  (bus_rdata),
    .irq_req    (irq_req),
    .mask       (mask_q),
    .cpu_irq    (cpu_irq),
    .pend_idx   (pend_idx),
    .pend_valid (pend_valid)
);

// File: tb/pci_irq_summary_test.sv
module pci_irq_summary_test;
    localparam int CLK_PERIOD = 10;
    localparam logic [11:0] BASE = 12'h804;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [7:0]  bus_wdata = '0;
    logic [7:0]  bus_rdata;
    logic [18:0] irq_req = '0;
    logic        cpu_irq;
    logic [4:0]  pend_idx;
    logic        pend_valid;

    int total = 0;
    int bad = 0;
    bit done = 0;

    logic [18:0] m_mask;
    logic [7:0]  e_rdata;

    always #(CLK_PERIOD/2) clk = ~clk;

    pci_irq_summary uut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq_req(irq_req), .cpu_irq(cpu_irq), .pend_idx(pend_idx),
        .pend_valid(pend_valid)
    );

    task automatic check(input bit ok, input string tag, input string what,
                         input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    function automatic logic [7:0] req_byte(input logic [18:0] r, input int k);
        logic [23:0] pad;
        pad = {5'b0, r};
        return pad[k*8 +: 8];
    endfunction

    // one clock: model computed from pre-edge values, compared after the edge
    task automatic cycle(input string tag);
        logic [18:0] p;
        bit          e_irq;
        int          e_idx;
        int          k;
        p = irq_req & ~m_mask;
        e_irq = (p != 0);
        e_idx = 0;
        for (int i = 18; i >= 0; i--) if (p[i]) e_idx = i;
        k = int'(bus_addr) - int'(BASE);
        if (bus_wr) begin
            if (k >= 0 && k < 3) begin
                for (int b = 0; b < 8; b++)
                    if (k*8 + b < 19) m_mask[k*8 + b] = bus_wdata[b];
            end
        end else if (bus_rd) begin
            e_rdata = (k >= 0 && k < 3) ? req_byte(irq_req, k) : 8'hFF;
        end
        @(posedge clk);
        @(negedge clk);
        check(cpu_irq == e_irq, tag, "cpu_irq (R5)", int'(cpu_irq), int'(e_irq));
        check(pend_valid == e_irq && int'(pend_idx) == e_idx, tag, "pend (R6)",
              int'({pend_valid, pend_idx}), e_irq ? (32 | e_idx) : 0);
        check(bus_rdata == e_rdata, tag, "rdata (R8)", int'(bus_rdata), int'(e_rdata));
    endtask

    task automatic wr(input logic [11:0] a, input logic [7:0] d, input string tag);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        cycle(tag);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, input string tag);
        bus_addr = a; bus_rd = 1'b1;
        cycle(tag);
        bus_rd = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog: actual=hung expected=finished");
        finish_run();
    end

    initial begin
        m_mask = '1;
        e_rdata = 8'h00;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset values
        check(cpu_irq == 0 && pend_valid == 0 && pend_idx == 0 && bus_rdata == 0,
              "R1", "reset outputs", int'({cpu_irq, pend_valid, pend_idx, bus_rdata}), 0);
        // R1 all requests, all masked
        irq_req = '1;
        cycle("R1");
        cycle("R1");
        // R3 raw read under full mask
        rd(BASE, "R3");
        rd(BASE + 1, "R3");
        rd(BASE + 2, "R4");
        // R2 enable byte 0, cascade line 4 only
        irq_req = 19'h00010;
        wr(BASE, 8'h00, "R2");
        cycle("R2");
        // R9 drop request
        irq_req = '0;
        cycle("R9");
        cycle("R9");
        // R6 lowest pending skips masked lines
        wr(BASE, 8'h0F, "R2");
        irq_req = 19'h000FF;
        cycle("R6");
        // R4 top byte: upper bits ignored, line 18 only
        wr(BASE + 2, 8'hFB, "R4");
        irq_req = 19'h40000;
        cycle("R4");
        rd(BASE + 2, "R4");
        irq_req = 19'h7FFFF;
        rd(BASE + 2, "R4");
        // R7 out-of-range write and reads
        wr(BASE + 3, 8'h00, "R7");
        wr(BASE - 1, 8'h00, "R7");
        irq_req = 19'h00F00;
        cycle("R7");
        rd(BASE + 3, "R7");
        rd(BASE - 1, "R7");
        // R2 enable byte 1, multiple lines
        wr(BASE + 1, 8'h00, "R2");
        cycle("R6");
        // R3 raw read under clear mask
        wr(BASE, 8'h00, "R3");
        irq_req = 19'h2A5C3;
        rd(BASE, "R3");
        rd(BASE + 1, "R3");
        // R8 hold
        irq_req = 19'h15A3C;
        cycle("R8");
        cycle("R8");
        // random traffic
        for (int n = 0; n < 400; n++) begin
            int op;
            irq_req = 19'($urandom);
            op = int'($urandom % 4);
            bus_addr = BASE - 1 + 12'($urandom % 5);
            bus_wdata = 8'($urandom);
            bus_wr = (op == 0);
            bus_rd = (op == 1);
            cycle("R5");
            bus_wr = 1'b0;
            bus_rd = 1'b0;
        end
        finish_run();
    end
endmodule